// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 style management transactions between a host register port and an external PHY over a two-wire management bus. Software writes one 32-bit command word into the frame register. The word holds the start code, the opcode, the PHY and register addresses, the turnaround code and sixteen data bits. The controller derives the management clock from the system clock with a programmable divider. Each transaction sends a run of ones as preamble, then shifts the command word out most significant bit first.

For a read, the controller releases the data pin during the turnaround. It then samples the sixteen bits the PHY returns and places them in the low half of the frame register. When the last bit is done, a sticky completion flag is raised. Software clears the flag by writing a one to it. A busy bit shows that a transaction is in flight. Transactions can only start while the management enable bit is set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every register reads zero, `mdc` is low and `mdio_oe` is low.
- R2: A write to address 0 while the enable bit (address 3, bit 2) is set and no transaction is running stores the word and starts a transaction. Bit 31 of address 3 reads 1 from that point until the transaction completes.
- R3: Each transaction begins with PRE_BITS (32) MDC periods in which `mdio_o` is 1 and `mdio_oe` is 1.
- R4: After the preamble, the 32 bits of the stored word appear on `mdio_o`, bit 31 first. A driven bit changes only while MDC is low, and it holds steady through each MDC high phase.
- R5: When bits [29:28] of the word are 10 (read), `mdio_oe` is low from frame bit position 15 (command bit 16, the second turnaround bit) to the end of the frame. Any other opcode keeps `mdio_oe` high for all 32 frame bits.
- R6: On a read, `mdio_i` is sampled at the MDC rising edge of each of the last 16 frame bits, and these bits form address-0 bits [15:0] with the first one as bit 15. Bits [31:16] keep the command.
- R7: Each MDC high or low phase lasts 2*F system clocks. F is the divider field in bits [6:1] of address 1, and an F of 0 acts as 1.
- R8: Completion sets bit 23 of address 2. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R9: A write to address 0 during a transaction is ignored. The frame on the pins and the stored word are unchanged.
- R10: A write to address 0 while the enable bit is clear is ignored. No transaction starts, and address 0 keeps its old value.
- R11: While idle, `mdc` stays low and `mdio_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 frame, 1 divider, 2 event, 3 control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pin |

## Verification
The assertions assume several things about the inputs. Register writes are single-cycle strobes, and the divider field is not changed while a transaction is running. `mdio_i` only matters during the read data window. The bench meets these rules in three ways. It programs the divider before each start, holds it until the busy bit drops, and drives `mdio_i` only after each observed MDC fall. The random commands always carry a legal start and turnaround code, a read or write opcode and divider values from 0 to 3. Directed cases add a write during a transaction and a start attempt while the enable bit is clear.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_W    = 6,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOTAL = PRE_BITS + 32;
  localparam int IDX_W = $clog2(TOTAL + 1);

  logic [31:0]      dreg;
  logic [DIV_W-1:0] div;
  logic             evt, en, busy, rd;
  logic [DIV_W:0]   cnt;
  logic [IDX_W-1:0] idx;

  wire [DIV_W:0]   half     = (div == '0) ? (DIV_W+1)'(2) : {div, 1'b0};
  wire             tick     = cnt >= half - 1'b1;
  wire             in_frame = idx >= IDX_W'(PRE_BITS);
  wire [IDX_W-1:0] fpos     = idx - IDX_W'(PRE_BITS);
  wire [4:0]       bsel     = 5'd31 - fpos[4:0];
  wire             start    = reg_wr && reg_addr == 2'd0 && en && !busy;

  assign mdio_o  = busy ? (in_frame ? dreg[bsel] : 1'b1) : 1'b1;
  assign mdio_oe = busy & ~(rd & in_frame & (fpos >= IDX_W'(15)));

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = dreg;
      2'd1:    reg_rdata = {{(31-DIV_W){1'b0}}, div, 1'b0};
      2'd2:    reg_rdata = {8'd0, evt, 23'd0};
      default: reg_rdata = {busy, 28'd0, en, 2'd0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg <= '0; div <= '0; evt <= 1'b0; en <= 1'b0; busy <= 1'b0;
      rd <= 1'b0; cnt <= '0; idx <= '0; mdc <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) div <= reg_wdata[DIV_W:1];
      if (reg_wr && reg_addr == 2'd3) en <= reg_wdata[2];
      if (reg_wr && reg_addr == 2'd2 && reg_wdata[23]) evt <= 1'b0;
      if (start) begin
        dreg <= reg_wdata;
        busy <= 1'b1;
        rd   <= reg_wdata[29:28] == 2'b10;
        idx  <= '0;
        cnt  <= '0;
        mdc  <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          mdc <= ~mdc;
          if (!mdc) begin
            if (rd && in_frame && fpos >= IDX_W'(16)) dreg[bsel] <= mdio_i;
          end else if (idx == IDX_W'(TOTAL - 1)) begin
            busy <= 1'b0;
            evt  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       en,
  input logic       evt
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && en && !busy) |=> busy);

  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

  a_r5_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  a_r8_done_raises_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt);

  a_r10_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !en && !busy) |=> !busy);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (.*);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, mdio_i = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(input bit is_rd, input logic [4:0] phy,
                                         input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, is_rd ? 2'b10 : 2'b01, phy, ra, 2'b10, d};
  endfunction

  function automatic int exp_half(input int f);
    return (f == 0) ? 2 : 2 * f;
  endfunction

  task automatic run_txn(input logic [31:0] cmd, input logic [15:0] phy, input int f, input bit disturb);
    bit o_seen[64], oe_seen[64];
    bit is_rd, prev, bad_half, dist_done, dist_now;
    int k, clks, ntog, guard, bad_pre, bad_frm, bad_oe;
    logic [31:0] v;
    is_rd = cmd[29:28] == 2'b10;
    wr(2'd1, 32'(f) << 1);
    mdio_i = 1'b1;
    wr(2'd0, cmd);
    reg_addr = 2'd3; #1;
    chk(reg_rdata[31] == 1'b1, "R2 busy after start", reg_rdata, 32'h8000_0004);
    prev = mdc; k = 0; clks = 0; ntog = 0; bad_half = 0; dist_done = 0; dist_now = 0;
    for (guard = 0; guard < 20000 && k < 64; guard++) begin
      @(negedge clk);
      clks++;
      if (dist_now) begin reg_wr = 1'b0; reg_addr = 2'd3; dist_now = 0; end
      if (mdc !== prev) begin
        if (ntog > 0 && clks != exp_half(f)) bad_half = 1;
        ntog++; clks = 0; prev = mdc;
        if (mdc) begin
          o_seen[k] = mdio_o; oe_seen[k] = mdio_oe;
        end else begin
          k++;
          mdio_i = (k >= 48 && k < 64) ? phy[63-k] : 1'b1;
        end
      end
      if (disturb && !dist_done && k == 20) begin
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ~cmd; dist_done = 1; dist_now = 1;
      end
    end
    reg_wr = 1'b0;
    chk(k == 64, "R2 transaction completes", 32'(k), 32'd64);
    bad_pre = 0; bad_frm = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      bit eoe;
      eoe = !(is_rd && i >= 47);
      if (i < 32 && (o_seen[i] != 1'b1 || oe_seen[i] != 1'b1)) bad_pre++;
      if (i >= 32 && eoe && o_seen[i] != cmd[63-i]) bad_frm++;
      if (oe_seen[i] != eoe) bad_oe++;
    end
    chk(bad_pre == 0, "R3 preamble ones driven", 32'(bad_pre), 32'd0);
    chk(bad_frm == 0, "R4 frame bits msb first", 32'(bad_frm), 32'd0);
    chk(bad_oe == 0, "R5 output enable pattern", 32'(bad_oe), 32'd0);
    chk(!bad_half, "R7 mdc half period", 32'(bad_half), 32'd0);
    rd(2'd3, v);
    chk(v[31] == 1'b0, "R2 busy clears at end", v, 32'h0000_0004);
    rd(2'd0, v);
    if (is_rd) chk(v == {cmd[31:16], phy}, "R6 read data captured", v, {cmd[31:16], phy});
    else chk(v == cmd, disturb ? "R9 busy write ignored" : "R4 stored word kept", v, cmd);
    rd(2'd2, v);
    chk(v == 32'h0080_0000, "R8 completion event set", v, 32'h0080_0000);
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, v);
    chk(v == 32'h0080_0000, "R8 write zero keeps event", v, 32'h0080_0000);
    wr(2'd2, 32'h0080_0000);
    rd(2'd2, v);
    chk(v == 32'h0, "R8 write one clears event", v, 32'h0);
  endtask

  initial begin
    #(200000.0 * 5.0);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v0, c;
    bit mdc_seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 32'h0, "R1 register reset value", v, 32'h0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle at reset", {30'd0, mdc, mdio_oe}, 32'h0);
    wr(2'd3, 32'h4);
    repeat (5) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 idle quiet", {30'd0, mdc, mdio_oe}, 32'h0);

    run_txn(mk_cmd(1'b1, 5'h01, 5'h02, 16'h0000), 16'hA5C3, 0, 1'b0);
    run_txn(mk_cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF), 16'h0000, 1, 1'b0);
    run_txn(mk_cmd(1'b1, 5'h00, 5'h00, 16'h0000), 16'hFFFF, 2, 1'b0);
    run_txn(mk_cmd(1'b1, 5'h0A, 5'h05, 16'h1234), 16'h8001, 1, 1'b1);
    run_txn(mk_cmd(1'b0, 5'h13, 5'h0C, 16'h5A5A), 16'h0000, 3, 1'b1);
    for (int n = 0; n < 8; n++) begin
      c = mk_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom));
      run_txn(c, 16'($urandom), int'($urandom % 4), 1'b0);
    end

    wr(2'd3, 32'h0);
    rd(2'd0, v0);
    wr(2'd0, 32'h6ABC_1234);
    mdc_seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc) mdc_seen = 1;
    end
    chk(!mdc_seen, "R10 no mdc while disabled", 32'(mdc_seen), 32'd0);
    rd(2'd3, v);
    chk(v[31] == 1'b0, "R10 not busy while disabled", v, 32'h0);
    rd(2'd0, v);
    chk(v == v0, "R10 frame register unchanged", v, v0);
    chk(mdio_oe == 1'b0, "R11 oe low when idle", 32'(mdio_oe), 32'd0);
    wr(2'd3, 32'h4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule